// File: doc/BRIEF.md
# Power-Gated Virtual-Channel Input Buffer

This block is the input buffer of one virtual channel in an on-chip router, with its own power-gating sequencer. Flits are held in a small register FIFO, four entries of 64 bits by default. When the channel has been idle for long enough, the sequencer raises a power-switch control that cuts the supply to the buffer. When traffic comes back, it takes the buffer through a waking phase of programmable length before it accepts data again.

A wake can be started by a flit that arrives at a sleeping channel, or by an early look-ahead request from the upstream router. The early request lets the waking phase overlap the flit's travel. A programmable idle-hold count sets the minimum run of empty cycles before the channel sleeps. This keeps the channel from toggling on and off for sleeps shorter than the energy break-even length. A write offered while the channel is not active is refused through the buffer-available flag and reported on a stall output. Such a write is never absorbed silently.

Top module: `vc_pg_buffer`

## Requirements
- R1: In the active state the buffer returns accepted flits in arrival order on `rd_data`. It holds at most DEPTH (default 4) flits, and `wr_ready` is low while DEPTH flits are held.
- R2: During and directly after reset the channel is asleep: `pwr_sleep`=1, `wr_ready`=0, `rd_valid`=0.
- R3: While asleep or waking, `wr_ready` and `rd_valid` are 0 and an offered write is not stored. `stall` equals `wr_valid` in those states and is 0 while active.
- R4: A sleeping channel begins to wake on the cycle `wr_valid` or `early_wake` is high. With `wake_lat`=L it is active (`wr_ready`=1) L+1 cycles after that cycle for L>0, and 1 cycle after it for L=0. `pwr_sleep` is 0 from the first cycle after the request.
- R5: An active channel raises `pwr_sleep` only after `idle_hold`=H consecutive cycles in which it is empty, receives no accepted write and sees no `early_wake`. An `idle_hold` of 0 acts as 1.
- R6: `early_wake` high in an active cycle restarts the idle count, so the sleep moves out to H cycles after the last such cycle.
- R7: The buffer contents are discarded on entry to sleep, and a freshly woken channel holds no flits (`rd_valid`=0).
- R8: `rd_valid` is 1 exactly when the channel is active and holds at least one flit. A cycle with `rd_valid` and `rd_ready` both high removes the oldest flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| early_wake | input | 1 | Look-ahead wake request from the upstream router |
| wake_lat | input | LAT_W (3) | Number of waking cycles before the buffer is usable |
| idle_hold | input | HOLD_W (5) | Empty cycles required before sleeping (0 acts as 1) |
| wr_valid | input | 1 | Flit offered for writing |
| wr_data | input | DATA_W (64) | Flit to write |
| wr_ready | output | 1 | Buffer available; a write is accepted when both are high |
| rd_ready | input | 1 | Router pipeline takes the head flit |
| rd_valid | output | 1 | Head flit present on rd_data |
| rd_data | output | DATA_W (64) | Oldest stored flit |
| pwr_sleep | output | 1 | Power-switch control, 1 = supply cut |
| stall | output | 1 | Write offered while the channel cannot accept it |

## Verification
If the wake counter is off by one, `wr_ready` rises a cycle early or late relative to the request. A reference model that follows every cycle flags that on the very cycle it happens. If the idle counter is corrupted, `pwr_sleep` rises at the wrong cycle after the last write or early request. This includes a channel that sleeps while a look-ahead request is active. If a FIFO pointer drifts, the next read shows the wrong flit on `rd_data`, or `rd_valid` disagrees with the number of flits held. Both are visible in the first cycle after the fault.

// File: rtl/vc_pg_pkg.sv
package vc_pg_pkg;
  typedef enum logic [1:0] {
    PG_SLEEP  = 2'd0,
    PG_WAKING = 2'd1,
    PG_ACTIVE = 2'd2
  } pg_state_e;
endpackage

// File: rtl/vc_pg_fifo.sv
module vc_pg_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign rdata = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PTR_W'(i))) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/vc_pg_sleep_ctrl.sv
module vc_pg_sleep_ctrl
  import vc_pg_pkg::*;
#(
  parameter int LAT_W  = 3,
  parameter int HOLD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_req,
  input  logic              keep_awake,
  input  logic              buf_empty,
  input  logic              push,
  input  logic [LAT_W-1:0]  wake_lat,
  input  logic [HOLD_W-1:0] idle_hold,
  output logic              flush,
  output logic              pwr_sleep,
  output logic              active
);
  pg_state_e         state, state_nx;
  logic [LAT_W-1:0]  wake_cnt;
  logic [HOLD_W-1:0] idle_cnt;
  logic              idle_tick, go_sleep, wake_start, wake_done;

  function automatic logic hold_reached(input logic [HOLD_W-1:0] cnt,
                                        input logic [HOLD_W-1:0] hold);
    logic [HOLD_W:0] seen, need;
    seen = {1'b0, cnt} + {{HOLD_W{1'b0}}, 1'b1};
    need = (hold == '0) ? {{HOLD_W{1'b0}}, 1'b1} : {1'b0, hold};
    return seen >= need;
  endfunction

  assign active     = (state == PG_ACTIVE);
  assign pwr_sleep  = (state == PG_SLEEP);
  assign idle_tick  = active && buf_empty && !push && !keep_awake;
  assign go_sleep   = idle_tick && hold_reached(idle_cnt, idle_hold);
  assign wake_start = (state == PG_SLEEP) && wake_req;
  assign wake_done  = (state == PG_WAKING) && (wake_cnt == LAT_W'(1));
  assign flush      = go_sleep;

  always_comb begin
    state_nx = state;
    unique case (state)
      PG_SLEEP:  if (wake_start) state_nx = (wake_lat == '0) ? PG_ACTIVE : PG_WAKING;
      PG_WAKING: if (wake_done)  state_nx = PG_ACTIVE;
      PG_ACTIVE: if (go_sleep)   state_nx = PG_SLEEP;
      default:   state_nx = PG_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PG_SLEEP;
      wake_cnt <= '0;
      idle_cnt <= '0;
    end else begin
      state <= state_nx;
      if (wake_start)               wake_cnt <= wake_lat;
      else if (state == PG_WAKING)  wake_cnt <= wake_cnt - LAT_W'(1);
      if (idle_tick && !go_sleep)   idle_cnt <= idle_cnt + HOLD_W'(1);
      else                          idle_cnt <= '0;
    end
  end

  a_r4_sleep_to_waking: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_start && wake_lat != '0) |=> (state == PG_WAKING && wake_cnt == $past(wake_lat)));
  a_r4_lat0_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_start && wake_lat == '0) |=> active);
  a_r4_waking_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_WAKING && wake_cnt != LAT_W'(1))
      |=> (state == PG_WAKING && wake_cnt == $past(wake_cnt) - LAT_W'(1)));
  a_r5_sleep_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_sleep) |-> $past(buf_empty && !push && !keep_awake));
  a_r3_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_SLEEP && !wake_req) |=> pwr_sleep);
endmodule

// File: rtl/vc_pg_buffer.sv
module vc_pg_buffer #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int LAT_W  = 3,
  parameter int HOLD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_wake,
  input  logic [LAT_W-1:0]  wake_lat,
  input  logic [HOLD_W-1:0] idle_hold,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwr_sleep,
  output logic              stall
);
  logic ev_push, ev_pop, ev_flush;
  logic buf_empty, buf_full, ch_active;

  assign wr_ready = ch_active && !buf_full;
  assign rd_valid = ch_active && !buf_empty;
  assign ev_push  = wr_valid && wr_ready;
  assign ev_pop   = rd_ready && rd_valid;
  assign stall    = wr_valid && !ch_active;

  vc_pg_sleep_ctrl #(.LAT_W(LAT_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_req   (wr_valid || early_wake),
    .keep_awake (early_wake),
    .buf_empty  (buf_empty),
    .push       (ev_push),
    .wake_lat   (wake_lat),
    .idle_hold  (idle_hold),
    .flush      (ev_flush),
    .pwr_sleep  (pwr_sleep),
    .active     (ch_active)
  );

  vc_pg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ev_flush),
    .push  (ev_push),
    .wdata (wr_data),
    .pop   (ev_pop),
    .rdata (rd_data),
    .empty (buf_empty),
    .full  (buf_full)
  );

  a_r3_closed_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_sleep |-> (!wr_ready && !rd_valid));
  a_r3_stall_refused: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !wr_ready);
  a_r7_wake_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_sleep) |-> !rd_valid);
endmodule

// File: tb/vc_pg_buffer_tb.sv
module vc_pg_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 0, rst_n = 0;
  logic        i_ew = 0, i_wv = 0, i_rr = 0;
  logic [2:0]  i_lat = 0;
  logic [4:0]  i_hold = 0;
  logic [63:0] i_wd = 0;
  logic        wr_ready, rd_valid, pwr_sleep, stall;
  logic [63:0] rd_data;

  int errors = 0, checks = 0, wd = 0;

  int          m_st = 0;   // 0 asleep, 1 waking, 2 active
  int          m_cnt = 0, m_idle = 0;
  logic [63:0] m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_pg_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .early_wake(i_ew), .wake_lat(i_lat), .idle_hold(i_hold),
    .wr_valid(i_wv), .wr_data(i_wd), .wr_ready(wr_ready), .rd_ready(i_rr),
    .rd_valid(rd_valid), .rd_data(rd_data), .pwr_sleep(pwr_sleep), .stall(stall)
  );

  function automatic int wake_cycles(input int lat);
    return (lat == 0) ? 1 : lat + 1;
  endfunction

  function automatic int hold_cycles(input int h);
    return (h < 1) ? 1 : h;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit act_e, wr_e, rv_e;
    act_e = (m_st == 2);
    wr_e  = act_e && (m_q.size() < 4);
    rv_e  = act_e && (m_q.size() > 0);
    chk(wr_ready == wr_e, act_e ? "R1" : "R3", "wr_ready", 64'(wr_ready), 64'(wr_e));
    chk(rd_valid == rv_e, act_e ? "R8" : "R3", "rd_valid", 64'(rd_valid), 64'(rv_e));
    chk(pwr_sleep == (m_st == 0), "R5", "pwr_sleep", 64'(pwr_sleep), 64'(m_st == 0));
    chk(stall == (i_wv && !act_e), "R3", "stall", 64'(stall), 64'(i_wv && !act_e));
    if (rv_e) chk(rd_data == m_q[0], "R1", "rd_data", rd_data, m_q[0]);
  endtask

  task automatic model_step();
    bit act_e, push, pop, was_empty;
    act_e = (m_st == 2);
    push = i_wv && act_e && (m_q.size() < 4);
    pop  = i_rr && act_e && (m_q.size() > 0);
    was_empty = (m_q.size() == 0);
    case (m_st)
      0: begin
        m_idle = 0;
        if (i_wv || i_ew) begin
          if (i_lat == 0) m_st = 2;
          else begin m_st = 1; m_cnt = int'(i_lat); end
        end
      end
      1: begin
        m_idle = 0;
        if (m_cnt == 1) m_st = 2; else m_cnt--;
      end
      default: begin
        if (pop) void'(m_q.pop_front());
        if (push) m_q.push_back(i_wd);
        if (was_empty && !push && !i_ew) begin
          if (m_idle + 1 >= hold_cycles(int'(i_hold))) begin
            m_st = 0; m_idle = 0; m_q.delete();
          end else m_idle++;
        end else m_idle = 0;
      end
    endcase
  endtask

  task automatic cyc();
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    i_ew = 0; i_wv = 0; i_rr = 0;
  endtask

  task automatic go_to_sleep();
    idle_inputs();
    i_hold = 1;
    for (int k = 0; k < 40 && !pwr_sleep; k++) cyc();
  endtask

  task automatic measure_wake(input int lat);
    int n;
    go_to_sleep();
    i_lat = 3'(lat);
    i_ew = 1;
    cyc();
    i_ew = 0;
    n = 1;
    while (!wr_ready && n < 20) begin cyc(); n++; end
    chk(n == wake_cycles(lat), "R4", "wake cycles", 64'(n), 64'(wake_cycles(lat)));
    chk(rd_valid == 0, "R7", "flits after wake", 64'(rd_valid), 64'd0);
  endtask

  task automatic measure_hold(input int h);
    int n;
    i_hold = 5'(h);
    n = 0;
    while (!pwr_sleep && n < 40) begin cyc(); n++; end
    chk(n == hold_cycles(h), "R5", "idle cycles to sleep", 64'(n), 64'(hold_cycles(h)));
  endtask

  task automatic run_rand(input int n, input int pw, input int pr, input int pe);
    for (int k = 0; k < n; k++) begin
      i_wv = ($urandom % 100) < pw;
      i_rr = ($urandom % 100) < pr;
      i_ew = ($urandom % 100) < pe;
      i_wd = {$urandom, $urandom};
      if (($urandom % 64) == 0) begin
        i_lat  = 3'($urandom % 8);
        i_hold = 5'($urandom % 12);
      end
      cyc();
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      errors++;
      $display("FAIL R4 watchdog: cycles=%0d expected<=%0d", wd, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(pwr_sleep == 1 && wr_ready == 0 && rd_valid == 0, "R2", "in reset",
        {61'd0, pwr_sleep, wr_ready, rd_valid}, 64'h4);
    rst_n = 1;
    @(negedge clk);
    chk(pwr_sleep == 1 && wr_ready == 0 && rd_valid == 0, "R2", "after reset",
        {61'd0, pwr_sleep, wr_ready, rd_valid}, 64'h4);

    // R3: write offered to a sleeping channel with latency 2 is stalled and not kept
    i_lat = 2; i_hold = 6; i_wv = 1; i_wd = 64'hDEAD;
    cyc();
    chk(pwr_sleep == 0 && wr_ready == 0, "R3", "waking refuses write",
        {62'd0, pwr_sleep, wr_ready}, 64'd0);
    i_wv = 0;
    cyc(); cyc();
    chk(wr_ready == 1 && rd_valid == 0, "R3", "refused write not stored",
        {62'd0, wr_ready, rd_valid}, 64'h2);

    // R1: fill to capacity, then drain in order
    for (int k = 0; k < 5; k++) begin
      i_wv = 1; i_wd = 64'(k + 100);
      cyc();
    end
    chk(wr_ready == 0, "R1", "full after 4 flits", 64'(wr_ready), 64'd0);
    i_wv = 0; i_rr = 1;
    for (int k = 0; k < 4; k++) begin
      chk(rd_data == 64'(k + 100), "R1", "drain order", rd_data, 64'(k + 100));
      cyc();
    end
    i_rr = 0;
    chk(rd_valid == 0, "R8", "empty after drain", 64'(rd_valid), 64'd0);

    // R4 / R7: wake latency for several settings, R5: idle hold incl. zero
    measure_wake(0);  measure_hold(0);
    measure_wake(3);  measure_hold(5);
    measure_wake(7);  measure_hold(1);
    measure_wake(1);

    // R6: early wake in active restarts the idle count
    i_hold = 4;
    cyc(); cyc();
    i_ew = 1; cyc(); i_ew = 0;
    n = 0;
    while (!pwr_sleep && n < 40) begin cyc(); n++; end
    chk(n == 4, "R6", "sleep delayed by early wake", 64'(n), 64'd4);

    // random phases with differing traffic mixes
    run_rand(1500, 60, 50, 5);
    run_rand(1500, 8, 70, 2);
    run_rand(1500, 90, 20, 0);
    run_rand(1500, 3, 90, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule